// File: doc/BRIEF.md
# Cell Receive Buffer Admission Controller

This block sits at the front of a cell receiver. It decides, one cell at a time, whether an arriving fixed-size cell is written to a receive buffer or dropped. Each cell comes with a channel number, a 3-bit payload-type field, the channel's operating mode and the channel's congestion-report enable. The block also samples an input that says whether an empty receive buffer is ready for that channel. It does not store payload, check lengths or CRCs, or manage buffer descriptors. It only gives a verdict and raises event pulses for a downstream writer and an interrupt collector.

The two modes handle a buffer shortage differently. In single-cell mode every cell stands alone. A cell that finds no buffer is dropped with a busy event, and the next cell on that channel tries the same buffer again. In frame mode a shortage spoils the whole frame. The first dropped cell reports busy, and the channel then silently drops every later cell up to and including the frame's last cell. The first cell of the next frame tries the buffer again. A small per-channel flag table holds this discard state, so channels never disturb one another.

All results are registered. They appear one clock after the cell is presented and are tagged with the cell's channel number.

Top module: `cell_rx_admit`

## Requirements
- R1: While reset is held and in the first cycle after it, every output strobe is low and `out_chan` is zero. After reset no channel is in the discard state.
- R2: A cell presented with `cell_vld` high gives, in the next cycle, exactly one of `store_vld` or `discard_vld`, with `out_chan` equal to the cell's channel. A cycle with `cell_vld` low gives all strobes and events low in the next cycle.
- R3: A single-cell-mode cell (`cell_frame_mode`=0) with `buf_avail`=1 is stored.
- R4: A single-cell-mode cell with `buf_avail`=0 is discarded with `busy_evt`. The next cell on that channel is admitted normally, which means it is stored if a buffer is available.
- R5: A frame-mode cell on a channel that is not discarding, with `buf_avail`=1, is stored. If its end-of-frame bit (`cell_pt[0]`) is 1, `frame_evt` is also raised.
- R6: A frame-mode cell on a channel that is not discarding, with `buf_avail`=0, is discarded with `busy_evt` and without `frame_evt`. The channel enters the discard state unless that cell has `cell_pt[0]`=1.
- R7: A frame-mode cell on a discarding channel is discarded whatever `buf_avail` is, with neither `busy_evt` nor `frame_evt`. If it has `cell_pt[0]`=1, the channel leaves the discard state, and the next frame's first cell is admitted normally.
- R8: The discard state is kept separately for each channel. Cells on other channels neither change it nor are affected by it.
- R9: `cong_evt` is raised for a cell exactly when `cell_pt[1]`=1 and `cell_cong_en`=1. This holds whether the cell is stored or discarded.
- R10: A single-cell-mode cell clears its channel's discard state.
- R11: `cell_pt[2]` has no effect on any output or on the channel state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_vld | input | 1 | A cell is presented this cycle |
| cell_chan | input | CH_W | Channel number of the cell |
| cell_pt | input | 3 | Payload type: bit 0 end of frame, bit 1 congestion, bit 2 ignored |
| cell_frame_mode | input | 1 | 1 = frame mode, 0 = single-cell mode |
| cell_cong_en | input | 1 | Channel reports congestion marks |
| buf_avail | input | 1 | An empty receive buffer is ready |
| store_vld | output | 1 | Cell is to be written to the buffer |
| discard_vld | output | 1 | Cell is dropped |
| busy_evt | output | 1 | Drop caused by buffer shortage reported |
| cong_evt | output | 1 | Congestion mark reported |
| frame_evt | output | 1 | Complete frame received |
| out_chan | output | CH_W | Channel the strobes and events refer to |

## Verification
A flag left set or cleared in error for a channel shows up only at that channel's next frame-mode cell. That cell becomes a wrong silent discard, or a wrong store or busy. The error can therefore stay hidden for as long as the channel stays idle. To expose this, the stimulus keeps returning to a few channels with short frames, and the bench's per-channel model is checked on every cell. A flag written to the wrong channel shows as a mismatch on a neighbouring channel, which the interleaved multi-channel sequences catch. Congestion and tagging errors appear in the very next cycle.

// File: rtl/cra_pkg.sv
package cra_pkg;
   // payload-type field layout
   localparam int PT_W    = 3;
   localparam int EOF_BIT = 0;
   localparam int CNG_BIT = 1;

   typedef struct packed {
      logic store;
      logic discard;
      logic busy;
      logic cong;
      logic frame;
   } cra_verdict_t;

   localparam cra_verdict_t CRA_IDLE = '{store: 1'b0, discard: 1'b0, busy: 1'b0,
                                         cong: 1'b0, frame: 1'b0};
endpackage

// File: rtl/cra_flag_table.sv
module cra_flag_table #(
   parameter int NUM_CH = 16,
   localparam int CH_W = $clog2(NUM_CH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [CH_W-1:0] rd_chan,
   output logic            rd_flag,
   input  logic            wr_en,
   input  logic [CH_W-1:0] wr_chan,
   input  logic            wr_flag
);
   logic [NUM_CH-1:0] flag_q;

   // one flop per channel, each with its own write decode
   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      always_ff @(posedge clk) begin
         if (!rst_n)
            flag_q[g] <= 1'b0;
         else if (wr_en && (wr_chan == CH_W'(g)))
            flag_q[g] <= wr_flag;
      end
   end

   assign rd_flag = flag_q[rd_chan];
endmodule

// File: rtl/cra_decide.sv
module cra_decide
   import cra_pkg::*;
(
   input  logic         vld,
   input  logic         frame_mode,
   input  logic         eof,
   input  logic         cng_mark,
   input  logic         cong_en,
   input  logic         buf_avail,
   input  logic         flag,
   output cra_verdict_t verdict,
   output logic         flag_we,
   output logic         flag_nxt
);
   always_comb begin
      verdict  = CRA_IDLE;
      flag_we  = 1'b0;
      flag_nxt = 1'b0;
      if (vld) begin
         flag_we      = 1'b1;
         verdict.cong = cng_mark & cong_en;
         if (!frame_mode) begin
            // stand-alone cell: retry every time, state cleared
            verdict.store   = buf_avail;
            verdict.discard = !buf_avail;
            verdict.busy    = !buf_avail;
            flag_nxt        = 1'b0;
         end else if (!flag) begin
            verdict.store   = buf_avail;
            verdict.discard = !buf_avail;
            verdict.busy    = !buf_avail;
            verdict.frame   = buf_avail & eof;
            flag_nxt        = !buf_avail & !eof;
         end else begin
            // rest of a spoiled frame: silent drop until its last cell
            verdict.discard = 1'b1;
            flag_nxt        = !eof;
         end
      end
   end
endmodule

// File: rtl/cra_event_reg.sv
module cra_event_reg
   import cra_pkg::*;
#(
   parameter int CH_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  cra_verdict_t    verdict_d,
   input  logic [CH_W-1:0] chan_d,
   output cra_verdict_t    verdict_q,
   output logic [CH_W-1:0] chan_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         verdict_q <= CRA_IDLE;
         chan_q    <= '0;
      end else begin
         verdict_q <= verdict_d;
         chan_q    <= chan_d;
      end
   end
endmodule

// File: rtl/cell_rx_admit.sv
module cell_rx_admit
   import cra_pkg::*;
#(
   parameter int NUM_CH = 16,
   localparam int CH_W = $clog2(NUM_CH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cell_vld,
   input  logic [CH_W-1:0] cell_chan,
   input  logic [2:0]      cell_pt,
   input  logic            cell_frame_mode,
   input  logic            cell_cong_en,
   input  logic            buf_avail,
   output logic            store_vld,
   output logic            discard_vld,
   output logic            busy_evt,
   output logic            cong_evt,
   output logic            frame_evt,
   output logic [CH_W-1:0] out_chan
);
   if (NUM_CH < 2 || (NUM_CH & (NUM_CH - 1)) != 0) begin : g_bad_nch
      $error("cell_rx_admit: NUM_CH must be a power of two and at least 2");
   end
   if (PT_W != 3) begin : g_bad_pt
      $error("cell_rx_admit: payload-type width must be 3");
   end

   logic         cur_flag;
   logic         flag_we;
   logic         flag_nxt;
   cra_verdict_t verdict_d;
   cra_verdict_t verdict_q;
   logic         unused_pt_hi;

   assign unused_pt_hi = cell_pt[2];

   cra_flag_table #(.NUM_CH(NUM_CH)) flags_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_chan (cell_chan),
      .rd_flag (cur_flag),
      .wr_en   (flag_we),
      .wr_chan (cell_chan),
      .wr_flag (flag_nxt)
   );

   cra_decide decide_i (
      .vld        (cell_vld),
      .frame_mode (cell_frame_mode),
      .eof        (cell_pt[EOF_BIT]),
      .cng_mark   (cell_pt[CNG_BIT]),
      .cong_en    (cell_cong_en),
      .buf_avail  (buf_avail),
      .flag       (cur_flag),
      .verdict    (verdict_d),
      .flag_we    (flag_we),
      .flag_nxt   (flag_nxt)
   );

   cra_event_reg #(.CH_W(CH_W)) out_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .verdict_d (verdict_d),
      .chan_d    (cell_chan),
      .verdict_q (verdict_q),
      .chan_q    (out_chan)
   );

   assign store_vld   = verdict_q.store;
   assign discard_vld = verdict_q.discard;
   assign busy_evt    = verdict_q.busy;
   assign cong_evt    = verdict_q.cong;
   assign frame_evt   = verdict_q.frame;
endmodule

// File: rtl/cell_rx_admit_chk.sv
module cell_rx_admit_chk #(
   parameter int CH_W = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cell_vld,
   input logic [CH_W-1:0] cell_chan,
   input logic [2:0]      cell_pt,
   input logic            cell_frame_mode,
   input logic            cell_cong_en,
   input logic            buf_avail,
   input logic            store_vld,
   input logic            discard_vld,
   input logic            busy_evt,
   input logic            cong_evt,
   input logic            frame_evt,
   input logic [CH_W-1:0] out_chan
);
   p_one_verdict_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cell_vld |=> (store_vld ^ discard_vld));

   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !cell_vld |=> !(store_vld | discard_vld | busy_evt | cong_evt | frame_evt));

   p_chan_tag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cell_vld |=> (out_chan == $past(cell_chan)));

   p_single_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cell_vld && !cell_frame_mode && buf_avail) |=> store_vld);

   p_single_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cell_vld && !cell_frame_mode && !buf_avail) |=> (discard_vld && busy_evt));

   p_frame_needs_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cell_vld && !cell_pt[0]) |=> !frame_evt);

   p_busy_is_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy_evt |-> (discard_vld && !frame_evt));

   p_frame_stored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_evt |-> store_vld);

   p_cong_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cell_vld && cell_pt[1] && cell_cong_en) |=> cong_evt);

   p_cong_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cell_vld && !(cell_pt[1] && cell_cong_en)) |=> !cong_evt);
endmodule

bind cell_rx_admit cell_rx_admit_chk #(.CH_W(CH_W)) chk_i (
   .clk             (clk),
   .rst_n           (rst_n),
   .cell_vld        (cell_vld),
   .cell_chan       (cell_chan),
   .cell_pt         (cell_pt),
   .cell_frame_mode (cell_frame_mode),
   .cell_cong_en    (cell_cong_en),
   .buf_avail       (buf_avail),
   .store_vld       (store_vld),
   .discard_vld     (discard_vld),
   .busy_evt        (busy_evt),
   .cong_evt        (cong_evt),
   .frame_evt       (frame_evt),
   .out_chan        (out_chan)
);

// File: tb/cell_rx_admit_tb_top.sv
module cell_rx_admit_tb_top;
   localparam int NCH = 16;
   localparam int CW  = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cell_vld;
   logic [CW-1:0] cell_chan;
   logic [2:0]    cell_pt;
   logic          cell_frame_mode;
   logic          cell_cong_en;
   logic          buf_avail;
   logic          store_vld, discard_vld, busy_evt, cong_evt, frame_evt;
   logic [CW-1:0] out_chan;

   always #5 clk = ~clk;

   cell_rx_admit #(.NUM_CH(NCH)) dut_i (
      .clk(clk), .rst_n(rst_n), .cell_vld(cell_vld), .cell_chan(cell_chan),
      .cell_pt(cell_pt), .cell_frame_mode(cell_frame_mode),
      .cell_cong_en(cell_cong_en), .buf_avail(buf_avail),
      .store_vld(store_vld), .discard_vld(discard_vld), .busy_evt(busy_evt),
      .cong_evt(cong_evt), .frame_evt(frame_evt), .out_chan(out_chan)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   bit mdl_disc [NCH];

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // requirement that governs a cell, from the model state
   function automatic string tag_of(bit v, bit fm, bit disc, bit ba);
      if (!v)   return "R2";
      if (!fm)  return ba ? "R3" : "R4";
      if (disc) return "R7";
      return ba ? "R5" : "R6";
   endfunction

   task automatic send(bit v, int ch, bit [2:0] pt, bit fm, bit ce, bit ba, string tag);
      bit e_st, e_di, e_bu, e_co, e_fr, nd, disc;
      string t;
      disc = mdl_disc[ch];
      e_st = 0; e_di = 0; e_bu = 0; e_co = 0; e_fr = 0; nd = disc;
      if (v) begin
         e_co = pt[1] & ce;
         if (!fm) begin
            e_st = ba; e_di = !ba; e_bu = !ba; nd = 0;
         end else if (!disc) begin
            e_st = ba; e_di = !ba; e_bu = !ba; e_fr = ba & pt[0]; nd = !ba & !pt[0];
         end else begin
            e_di = 1; nd = !pt[0];
         end
      end
      t = (tag != "") ? tag : tag_of(v, fm, disc, ba);
      cell_vld = v; cell_chan = CW'(ch); cell_pt = pt;
      cell_frame_mode = fm; cell_cong_en = ce; buf_avail = ba;
      @(posedge clk);
      @(negedge clk);
      chk(t, "store_vld", int'(store_vld), int'(e_st));
      chk(t, "discard_vld", int'(discard_vld), int'(e_di));
      chk(t, "busy_evt", int'(busy_evt), int'(e_bu));
      chk(t, "frame_evt", int'(frame_evt), int'(e_fr));
      chk("R9", "cong_evt", int'(cong_evt), int'(e_co));
      if (v) begin
         chk("R2", "out_chan", int'(out_chan), ch);
         mdl_disc[ch] = nd;
      end
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      foreach (mdl_disc[i]) mdl_disc[i] = 0;
      rst_n = 0; cell_vld = 0; cell_chan = '0; cell_pt = '0;
      cell_frame_mode = 0; cell_cong_en = 0; buf_avail = 0;
      repeat (3) @(negedge clk);
      chk("R1", "strobes in reset",
          int'({store_vld, discard_vld, busy_evt, cong_evt, frame_evt}), 0);
      chk("R1", "out_chan in reset", int'(out_chan), 0);
      rst_n = 1;
      @(negedge clk);
      chk("R1", "strobes after reset",
          int'({store_vld, discard_vld, busy_evt, cong_evt, frame_evt}), 0);

      // R1: every channel starts non-discarding
      for (int c = 0; c < NCH; c++) send(1, c, 3'b001, 1, 0, 1, "R1");

      // R4: single-mode shortage then immediate retry
      send(1, 3, 3'b000, 0, 0, 0, "R4");
      send(1, 3, 3'b000, 0, 0, 1, "R4");

      // R6/R7: shortage mid-frame, silent drop to end, retry next frame
      send(1, 5, 3'b000, 1, 0, 1, "R5");
      send(1, 5, 3'b000, 1, 0, 0, "R6");
      send(1, 5, 3'b000, 1, 0, 1, "R7");
      send(1, 5, 3'b001, 1, 0, 1, "R7");
      send(1, 5, 3'b001, 1, 0, 1, "R7");

      // R6: shortage on a last cell leaves the channel clear
      send(1, 6, 3'b001, 1, 0, 0, "R6");
      send(1, 6, 3'b001, 1, 0, 1, "R6");

      // R8: interleaved channels keep separate state
      send(1, 7, 3'b000, 1, 0, 0, "R8");
      send(1, 8, 3'b000, 1, 0, 1, "R8");
      send(1, 8, 3'b001, 1, 0, 1, "R8");
      send(1, 7, 3'b000, 1, 0, 1, "R8");
      send(1, 7, 3'b001, 1, 0, 1, "R8");

      // R10: single-mode cell clears discard state
      send(1, 9, 3'b000, 1, 0, 0, "R10");
      send(1, 9, 3'b000, 0, 0, 1, "R10");
      send(1, 9, 3'b001, 1, 0, 1, "R10");

      // R11: bit 2 of payload type ignored
      send(1, 10, 3'b100, 1, 0, 1, "R11");
      send(1, 10, 3'b101, 1, 1, 1, "R11");
      send(1, 10, 3'b110, 1, 1, 0, "R11");
      send(1, 10, 3'b100, 1, 0, 1, "R11");

      // R9: congestion on stored and dropped cells, and masked
      send(1, 11, 3'b010, 0, 1, 0, "");
      send(1, 11, 3'b010, 0, 0, 1, "");
      send(0, 0, 3'b010, 1, 1, 1, "R2");

      // constrained random traffic on a few hot channels
      for (int n = 0; n < 4000; n++) begin
         bit v, fm, ce, ba;
         int ch;
         bit [2:0] pt;
         v  = ($urandom % 100) < 85;
         ch = (($urandom % 4) != 0) ? int'($urandom % 4) : int'($urandom % NCH);
         pt = 3'($urandom);
         pt[0] = ($urandom % 4) == 0;
         fm = ($urandom % 5) != 0;
         ce = $urandom % 2;
         ba = ($urandom % 100) < 70;
         send(v, ch, pt, fm, ce, ba, "");
      end

      send(0, 0, 3'b000, 0, 0, 0, "R2");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule